// File: doc/BRIEF.md
# Half-Bridge Cross-Conduction Lockout Sequencer

This block sits between a controller that issues separate high-side and low-side on-commands and the two gate-enable signals of one half-bridge. It never lets both devices be commanded on together. A device may turn on only after the opposite device has been sensed off. If the two commands overlap, the device that turned on first keeps control until its own command drops. Comparator results arrive as already-synchronised digital flags. One flag reports that the low-side gate voltage is below its off threshold. The other reports that the switch node has fallen below its threshold. All delays are counted in clock cycles and set by parameters.

Before the low side may turn on, a switch-node latch must be set. The latch sets as soon as the switch node is sensed low. If the node never falls, the latch sets after a timeout instead. The latch then holds until the low-side command drops, so ringing on the node cannot disturb a low-side turn-on that is already under way. The low side turns off within one cycle of its command falling. The high side turns off after a fixed drain delay.

The sequencer states are:
- `ST_IDLE`: both outputs off.
- `ST_HS_WAIT`: high side requested, waiting for the low-side gate to be sensed off.
- `ST_HS_ON`: high side on.
- `ST_HS_FALL`: high-side command gone, turn-off delay running with the output still on.
- `ST_LS_WAIT`: low side requested, waiting for the latch and then the turn-on delay.
- `ST_LS_ON`: low side on.

The transitions are:
- `ST_IDLE` goes to `ST_LS_WAIT` when the low command is high. Otherwise it goes to `ST_HS_WAIT` when the high command is high.
- `ST_HS_WAIT` goes to `ST_HS_ON` after TON_DLY consecutive cycles with the gate-off flag high. It returns to `ST_IDLE` if the high command drops.
- `ST_HS_ON` goes to `ST_HS_FALL` when the high command drops.
- `ST_HS_FALL` goes to `ST_LS_WAIT` after TOFF_DLY cycles if the low command is high, and to `ST_IDLE` otherwise.
- `ST_LS_WAIT` goes to `ST_LS_ON` after TON_DLY consecutive cycles with the latch set. It returns to `ST_IDLE` if the low command drops.
- `ST_LS_ON` goes to `ST_IDLE` when the low command drops.
- Enable low or reset forces `ST_IDLE` from any state.

Top module: `ccl_lockout_ctrl`

## Requirements
- R1: With both commands low, both gate outputs are low.
- R2: From idle, with `lo_gate_off` high throughout, `hs_gate` rises TON_DLY+1 clock edges after `hi_cmd` is first sampled high. While `lo_gate_off` is low, `hs_gate` stays low.
- R3: While one output is on and its own command stays high, raising the other command has no effect on either output. Once the owning command drops, the other side follows through its normal turn-on sequence.
- R4: `hs_gate` falls TOFF_DLY+1 edges after `hi_cmd` is first sampled low.
- R5: From idle, with `sw_node_low` high throughout, `ls_gate` rises TON_DLY+2 edges after `lo_cmd` is first sampled high.
- R6: If the switch node is never sensed low, the latch sets after SWTO_DLY cycles of pending low-side request. `ls_gate` then rises SWTO_DLY+TON_DLY+1 edges after `lo_cmd` is first sampled high. The latch clears whenever `lo_cmd` is low.
- R7: Once the latch is set, the switch-node flag returning high (ringing) neither delays nor removes the low-side output.
- R8: `ls_gate` falls on the first edge at which `lo_cmd` is sampled low.
- R9: A high command held for TON_DLY or fewer sampled cycles produces no high-side output pulse.
- R10: Reset or `en` low clears both outputs within one edge. When enable returns, sequencing restarts from idle.
- R11: `hs_gate` and `ls_gate` are never high in the same cycle.
- R12: If both commands rise in the same cycle from idle, the low side is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low forces both outputs off |
| hi_cmd | input | 1 | High-side on-command |
| lo_cmd | input | 1 | Low-side on-command |
| lo_gate_off | input | 1 | Synchronised flag: low-side gate below off threshold |
| sw_node_low | input | 1 | Synchronised flag: switch node below threshold |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The bench targets overlapping commands in both orders. A design that got priority wrong would hand the output to the late command, or turn both devices on together. It also covers a switch node that never falls, where a design missing the timeout would hold the low side off forever. Switch-node ringing after the latch has set is exercised; a design without the latch would delay the low-side turn-on or chop its output. The remaining cases are:
- short high-side pulses, which a design without the qualification counter would pass straight through;
- simultaneous command rises, where the low side must win;
- enable dropped mid-conduction, where a design that leaves state set would resume with a stale output.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HS_WAIT = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_HS_FALL = 3'd3,
        ST_LS_WAIT = 3'd4,
        ST_LS_ON   = 3'd5
    } ccl_state_e;
endpackage

// File: rtl/ccl_swnode_latch.sv
module ccl_swnode_latch #(
    parameter int SWTO_DLY = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic arm,
    input  logic lo_cmd,
    input  logic sw_node_low,
    output logic latched
);
    localparam int TW = $clog2(SWTO_DLY + 1);
    localparam logic [TW-1:0] TO_LAST = TW'(SWTO_DLY - 1);

    logic [TW-1:0] to_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latched <= 1'b0;
            to_cnt  <= '0;
        end else if (!en) begin
            latched <= 1'b0;
            to_cnt  <= '0;
        end else begin
            if (!lo_cmd)
                latched <= 1'b0;
            else if (arm && (sw_node_low || to_cnt == TO_LAST))
                latched <= 1'b1;
            to_cnt <= (arm && !latched) ? to_cnt + 1'b1 : '0;
        end
    end

    // R6
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_cmd |=> !latched);
endmodule

// File: rtl/ccl_seq_fsm.sv
module ccl_seq_fsm
    import ccl_pkg::*;
#(
    parameter int TON_DLY  = 2,
    parameter int TOFF_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic lo_gate_off,
    input  logic sw_latched,
    output logic ls_pending,
    output logic hs_gate,
    output logic ls_gate
);
    localparam int MAXD = (TON_DLY > TOFF_DLY) ? TON_DLY : TOFF_DLY;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(TON_DLY - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(TOFF_DLY - 1);

    ccl_state_e     state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = '0;
        unique case (state)
            ST_IDLE: begin
                if (lo_cmd)      state_nx = ST_LS_WAIT;
                else if (hi_cmd) state_nx = ST_HS_WAIT;
            end
            ST_HS_WAIT: begin
                if (!hi_cmd) state_nx = ST_IDLE;
                else if (lo_gate_off) begin
                    if (cnt == ON_LAST) state_nx = ST_HS_ON;
                    else                cnt_nx   = cnt + 1'b1;
                end
            end
            ST_HS_ON: begin
                if (!hi_cmd) state_nx = ST_HS_FALL;
            end
            ST_HS_FALL: begin
                if (cnt == OFF_LAST) state_nx = lo_cmd ? ST_LS_WAIT : ST_IDLE;
                else                 cnt_nx   = cnt + 1'b1;
            end
            ST_LS_WAIT: begin
                if (!lo_cmd) state_nx = ST_IDLE;
                else if (sw_latched) begin
                    if (cnt == ON_LAST) state_nx = ST_LS_ON;
                    else                cnt_nx   = cnt + 1'b1;
                end
            end
            ST_LS_ON: begin
                if (!lo_cmd) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        hs_gate    = (state == ST_HS_ON) || (state == ST_HS_FALL);
        ls_gate    = (state == ST_LS_ON);
        ls_pending = (state == ST_LS_WAIT);
    end

    // R11
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));
    // R2
    hs_sensed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> $past(lo_gate_off));
    // R8
    ls_prompt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate && !lo_cmd) |=> !ls_gate);
    // R3
    ls_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate && lo_cmd && en) |=> (ls_gate && !hs_gate));
    // R3
    hs_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_gate && en) |=> !ls_gate);
    // R10
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_gate && !ls_gate));
endmodule

// File: rtl/ccl_lockout_ctrl.sv
module ccl_lockout_ctrl #(
    parameter int TON_DLY  = 2,
    parameter int TOFF_DLY = 2,
    parameter int SWTO_DLY = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic lo_gate_off,
    input  logic sw_node_low,
    output logic hs_gate,
    output logic ls_gate
);
    logic sw_latched;
    logic ls_pending;

    ccl_swnode_latch #(.SWTO_DLY(SWTO_DLY)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .arm         (ls_pending),
        .lo_cmd      (lo_cmd),
        .sw_node_low (sw_node_low),
        .latched     (sw_latched)
    );

    ccl_seq_fsm #(.TON_DLY(TON_DLY), .TOFF_DLY(TOFF_DLY)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .hi_cmd      (hi_cmd),
        .lo_cmd      (lo_cmd),
        .lo_gate_off (lo_gate_off),
        .sw_latched  (sw_latched),
        .ls_pending  (ls_pending),
        .hs_gate     (hs_gate),
        .ls_gate     (ls_gate)
    );

    // R5
    ls_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> $past(sw_latched));
endmodule

// File: tb/test_ccl_lockout_ctrl.sv
`timescale 1ns/1ps
module test_ccl_lockout_ctrl;
    localparam int TON  = 2;
    localparam int TOFF = 2;
    localparam int SWTO = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, hi = 1'b0, lo = 1'b0, goff = 1'b0, swl = 1'b0;
    logic hs, ls;
    int checks = 0, failures = 0;
    string cur_req = "R10";

    always #10 clk = ~clk;

    ccl_lockout_ctrl #(.TON_DLY(TON), .TOFF_DLY(TOFF), .SWTO_DLY(SWTO)) i_ccl_lockout_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .hi_cmd(hi), .lo_cmd(lo),
        .lo_gate_off(goff), .sw_node_low(swl), .hs_gate(hs), .ls_gate(ls));

    // behavioural reference model
    bit m_hs = 0, m_ls = 0, hi_pend = 0, lo_pend = 0, drain = 0, lat = 0;
    int run = 0, tmo = 0;

    always @(posedge clk) begin : model_b
        bit nl;
        int nt;
        if (!rst_n || !en) begin
            m_hs = 0; m_ls = 0; hi_pend = 0; lo_pend = 0; drain = 0;
            lat = 0; run = 0; tmo = 0;
        end else begin
            nl = lat;
            if (!lo) nl = 0;
            else if (lo_pend && (swl || tmo == SWTO - 1)) nl = 1;
            nt = (lo_pend && !lat) ? tmo + 1 : 0;
            if (m_ls) begin
                if (!lo) m_ls = 0;
            end else if (m_hs && !drain) begin
                if (!hi) begin drain = 1; run = 0; end
            end else if (drain) begin
                run++;
                if (run == TOFF) begin
                    m_hs = 0; drain = 0; run = 0; lo_pend = lo;
                end
            end else if (hi_pend) begin
                if (!hi) begin hi_pend = 0; run = 0; end
                else if (goff) begin
                    run++;
                    if (run == TON) begin hi_pend = 0; m_hs = 1; run = 0; end
                end else run = 0;
            end else if (lo_pend) begin
                if (!lo) begin lo_pend = 0; run = 0; end
                else if (lat) begin
                    run++;
                    if (run == TON) begin lo_pend = 0; m_ls = 1; run = 0; end
                end else run = 0;
            end else begin
                if (lo) lo_pend = 1;
                else if (hi) hi_pend = 1;
                run = 0;
            end
            lat = nl;
            tmo = nt;
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
        checks++;
        if (hs !== m_hs || ls !== m_ls) begin
            failures++;
            $display("FAIL %s model: hs=%b ls=%b expected hs=%b ls=%b", cur_req, hs, ls, m_hs, m_ls);
        end
        if (hs === 1'b1 && ls === 1'b1) begin
            failures++;
            $display("FAIL R11 both on: hs=%b ls=%b expected not both", hs, ls);
        end
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_hs(output int n);
        n = 0;
        do begin tick(); n++; end while (hs !== 1'b1 && n < 40);
    endtask

    task automatic wait_ls(output int n);
        n = 0;
        do begin tick(); n++; end while (ls !== 1'b1 && n < 40);
    endtask

    initial begin
        #(20.0 * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int seen;
        repeat (3) tick();
        chk("R10 reset hs", hs, 0);
        chk("R10 reset ls", ls, 0);
        rst_n = 1'b1; en = 1'b1;

        // R1
        cur_req = "R1";
        repeat (3) tick();
        chk("R1 idle hs", hs, 0);
        chk("R1 idle ls", ls, 0);

        // R2 turn-on timing with gate sensed off
        cur_req = "R2";
        goff = 1; hi = 1;
        wait_hs(n);
        chk("R2 hs rise edges", n, TON + 1);

        // R4
        cur_req = "R4";
        hi = 0;
        n = 0;
        do begin tick(); n++; end while (hs === 1'b1 && n < 40);
        chk("R4 hs fall edges", n, TOFF + 1);

        // R2 gate not sensed off blocks turn-on
        cur_req = "R2";
        goff = 0; hi = 1;
        seen = 0;
        repeat (8) begin tick(); if (hs) seen = 1; end
        chk("R2 blocked while gate on", seen, 0);
        goff = 1;
        wait_hs(n);
        chk("R2 rise after sensing", n, TON);
        hi = 0;
        repeat (TOFF + 2) tick();

        // R5
        cur_req = "R5";
        swl = 1; lo = 1;
        wait_ls(n);
        chk("R5 ls rise edges", n, TON + 2);

        // R8
        cur_req = "R8";
        lo = 0;
        tick();
        chk("R8 ls prompt off", ls, 0);

        // R6 timeout
        cur_req = "R6";
        swl = 0; lo = 1;
        wait_ls(n);
        chk("R6 timeout rise edges", n, SWTO + TON + 1);
        lo = 0;
        tick();

        // R7 ringing after latch
        cur_req = "R7";
        swl = 1; lo = 1;
        tick(); tick();
        swl = 0;
        tick(); tick();
        chk("R7 ls on despite ringing", ls, 1);
        seen = 1;
        for (int i = 0; i < 6; i++) begin
            swl = i[0];
            tick();
            if (!ls) seen = 0;
        end
        chk("R7 ls held through ringing", seen, 1);

        // R3 low side owns, hi raised
        cur_req = "R3";
        swl = 1; goff = 1; hi = 1;
        seen = 0;
        repeat (6) begin tick(); if (hs || !ls) seen = 1; end
        chk("R3 hi ignored while low owns", seen, 0);
        lo = 0;
        wait_hs(n);
        chk("R3 hs after low release", n, TON + 2);

        // R3 high side owns, lo raised
        lo = 1;
        seen = 0;
        repeat (6) begin tick(); if (ls || !hs) seen = 1; end
        chk("R3 lo ignored while high owns", seen, 0);
        hi = 0;
        wait_ls(n);
        chk("R3 ls after high release", ls, 1);
        chk("R3 hs off when ls on", hs, 0);
        lo = 0;
        repeat (2) tick();

        // R9 short pulse
        cur_req = "R9";
        hi = 1;
        tick(); tick();
        hi = 0;
        seen = 0;
        repeat (6) begin tick(); if (hs) seen = 1; end
        chk("R9 short pulse no output", seen, 0);

        // R12 simultaneous
        cur_req = "R12";
        hi = 1; lo = 1;
        wait_ls(n);
        chk("R12 low first", ls, 1);
        chk("R12 high held off", hs, 0);
        lo = 0;
        wait_hs(n);

        // R10 enable drop mid-conduction
        cur_req = "R10";
        chk("R10 hs on before drop", hs, 1);
        en = 0;
        tick();
        chk("R10 en low clears hs", hs, 0);
        tick();
        en = 1;
        wait_hs(n);
        chk("R10 restart from idle", n, TON + 1);
        hi = 0;
        repeat (TOFF + 3) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule